// File: doc/BRIEF.md
# Square-Partitioned Adaptive LMS Filter

The block is a nine-tap adaptive transversal filter that tunes its own coefficients with the least-mean-square rule. Its taps are split into three short pipes of three cells each. A sample enters the first cell of the first pipe. On every accepted sample it moves one cell onward, and it crosses from the tail of one pipe into the head of the next. Each pipe forms its own partial sum, starting from zero, from the products of weight and sample in its cells. A small adder stage then combines the three partial sums into the filter output. A sample's contribution therefore passes through a chain about the square root of the tap count long, not the full tap count.

The error is the desired sample minus the filter output. It is broadcast to every cell in the same cycle. Each cell holds one weight and updates it locally. The correction is the product of the error and the cell's current sample, scaled down by a step-size shift. The user presents one input sample and one desired sample with a valid strobe, and may do so on every cycle. One cycle later the block returns the output and the error with their own valid flag. All cells work on every accepted sample.

Top module: `lms_part_filter`

## Requirements
- R1: While reset is asserted, and after it is released, out_valid is 0 and out_y and out_err are 0. Every weight starts at zero, so the first accepted sample after reset gives out_y = 0 and out_err = in_desired.
- R2: For each cycle with in_valid high, out_valid is high in the next cycle, and only then. Samples may arrive on consecutive cycles, and each one yields exactly one result.
- R3: A cycle with in_valid low changes no weight and no stored sample, whatever in_sample and in_desired carry. out_y and out_err keep their values through such cycles.
- R4: With x(n-k) the k-th previously accepted sample (zero if there is none since reset), tap k sits in pipe k/3 at position k%3. The output is y = sat16(sum over k=0..8 of p_k), where p_k = sat16(round(w_k * x(n-k) / 2^15)). Each pipe's partial sum starts from zero.
- R5: out_err = sat16(in_desired - y), where y is the output that accompanies it.
- R6: After each accepted sample, each weight becomes w_k = sat16(w_k + sat16(round(e * x(n-k) / 2^(15+MU_SHIFT)))), with MU_SHIFT defaulting to 4. The product for the next sample uses the updated weights, even when that sample arrives in the very next cycle.
- R7: round(v / 2^s) means adding 2^(s-1) and then shifting right arithmetically by s, so halves round toward plus infinity. sat16 clamps to the range [-32768, 32767]. Weights, products, sums and errors all saturate at these limits rather than wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Sample and desired value are present |
| in_sample | input | 16 | Input sample, signed Q1.15 |
| in_desired | input | 16 | Desired response, signed Q1.15 |
| out_valid | output | 1 | out_y and out_err belong to the previous accepted sample |
| out_y | output | 16 | Filter output, signed Q1.15 |
| out_err | output | 16 | Error, desired minus output, signed Q1.15 |

## Verification
The critical overlap is the weight update for sample n and the product for sample n+1. With back-to-back samples, both happen at the same clock edge, one using the error the other has just produced. The bench drives long runs of consecutive valid cycles, both in system-identification training and in runs that push values to full scale. It compares every output and error against a bit-exact model in which every update lands before the next product is formed. A design that used stale weights, or rounded or saturated differently, would drift from the model within a few samples.

// File: rtl/lms_pkg.sv
package lms_pkg;

   // round-half-up arithmetic shift right
   function automatic logic signed [63:0] rnd_shift(input logic signed [63:0] v,
                                                    input int unsigned sh);
      logic signed [63:0] half;
      if (sh == 0) return v;
      half = 64'sd1 <<< (sh - 1);
      return (v + half) >>> sh;
   endfunction

   // clamp to a signed range of w bits
   function automatic logic signed [63:0] clip(input logic signed [63:0] v,
                                               input int unsigned w);
      logic signed [63:0] hi;
      logic signed [63:0] lo;
      hi = (64'sd1 <<< (w - 1)) - 64'sd1;
      lo = -(64'sd1 <<< (w - 1));
      if (v > hi) return hi;
      if (v < lo) return lo;
      return v;
   endfunction

endpackage

// File: rtl/lms_cell.sv
module lms_cell #(
   parameter int DW          = 16,
   parameter int FRAC        = 15,
   parameter int MU_SHIFT    = 4,
   parameter int SUM_W       = 20,
   parameter bit KEEP_SAMPLE = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    adv,
   input  logic signed [DW-1:0]    smp_in,
   input  logic signed [DW-1:0]    err,
   input  logic signed [SUM_W-1:0] psum_in,
   output logic signed [DW-1:0]    smp_out,
   output logic signed [SUM_W-1:0] psum_out
);
   localparam int UPD_SH = FRAC + MU_SHIFT;

   logic signed [DW-1:0] wgt_q;
   logic signed [DW-1:0] prod_r;
   logic signed [DW-1:0] upd_r;
   logic signed [DW-1:0] wgt_nx;

   always_comb begin
      prod_r   = DW'(lms_pkg::clip(lms_pkg::rnd_shift(64'(wgt_q) * 64'(smp_in), FRAC), DW));
      upd_r    = DW'(lms_pkg::clip(lms_pkg::rnd_shift(64'(err) * 64'(smp_in), UPD_SH), DW));
      wgt_nx   = DW'(lms_pkg::clip(64'(wgt_q) + 64'(upd_r), DW));
      psum_out = psum_in + SUM_W'(prod_r);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   wgt_q <= '0;
      else if (adv) wgt_q <= wgt_nx;
   end

   generate
      if (KEEP_SAMPLE) begin : g_hold
         logic signed [DW-1:0] smp_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   smp_q <= '0;
            else if (adv) smp_q <= smp_in;
         end
         assign smp_out = smp_q;
      end else begin : g_tail
         assign smp_out = '0;
      end
   endgenerate
endmodule

// File: rtl/lms_pipe.sv
module lms_pipe #(
   parameter int DW       = 16,
   parameter int FRAC     = 15,
   parameter int MU_SHIFT = 4,
   parameter int SUM_W    = 20,
   parameter int CELLS    = 3,
   parameter bit IS_LAST  = 1'b0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    adv,
   input  logic signed [DW-1:0]    smp_in,
   input  logic signed [DW-1:0]    err,
   output logic signed [DW-1:0]    smp_out,
   output logic signed [SUM_W-1:0] psum
);
   logic signed [DW-1:0]    smp_chain [CELLS+1];
   logic signed [SUM_W-1:0] ps_chain  [CELLS+1];

   assign smp_chain[0] = smp_in;
   assign ps_chain[0]  = '0;

   generate
      for (genvar c = 0; c < CELLS; c++) begin : g_cell
         localparam bit KEEP = !(IS_LAST && (c == CELLS - 1));
         lms_cell #(
            .DW(DW), .FRAC(FRAC), .MU_SHIFT(MU_SHIFT),
            .SUM_W(SUM_W), .KEEP_SAMPLE(KEEP)
         ) cell_i (
            .clk(clk), .rst_n(rst_n), .adv(adv),
            .smp_in(smp_chain[c]), .err(err),
            .psum_in(ps_chain[c]),
            .smp_out(smp_chain[c+1]), .psum_out(ps_chain[c+1])
         );
      end
   endgenerate

   assign smp_out = smp_chain[CELLS];
   assign psum    = ps_chain[CELLS];
endmodule

// File: rtl/lms_part_filter.sv
module lms_part_filter #(
   parameter int DW       = 16,
   parameter int ROOT     = 3,
   parameter int FRAC     = 15,
   parameter int MU_SHIFT = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   input  logic signed [DW-1:0] in_sample,
   input  logic signed [DW-1:0] in_desired,
   output logic                 out_valid,
   output logic signed [DW-1:0] out_y,
   output logic signed [DW-1:0] out_err
);
   localparam int TAPS  = ROOT * ROOT;
   localparam int SUM_W = DW + $clog2(ROOT) + 1;
   localparam int TOT_W = DW + $clog2(TAPS) + 1;

   generate
      if (ROOT < 2)                 begin : g_bad_root $error("ROOT must be at least 2"); end
      if (DW < 4 || DW > 31)        begin : g_bad_dw   $error("DW out of range"); end
      if (FRAC < 1 || FRAC >= DW)   begin : g_bad_frac $error("FRAC must lie inside DW"); end
      if (MU_SHIFT < 0 || MU_SHIFT > 16) begin : g_bad_mu $error("MU_SHIFT out of range"); end
   endgenerate

   logic signed [DW-1:0]    link [ROOT+1];
   logic signed [SUM_W-1:0] psum [ROOT];
   logic signed [TOT_W-1:0] tot;
   logic signed [DW-1:0]    y_c;
   logic signed [DW-1:0]    e_c;

   assign link[0] = in_sample;

   generate
      for (genvar p = 0; p < ROOT; p++) begin : g_pipe
         lms_pipe #(
            .DW(DW), .FRAC(FRAC), .MU_SHIFT(MU_SHIFT),
            .SUM_W(SUM_W), .CELLS(ROOT), .IS_LAST(p == ROOT - 1)
         ) pipe_i (
            .clk(clk), .rst_n(rst_n), .adv(in_valid),
            .smp_in(link[p]), .err(e_c),
            .smp_out(link[p+1]), .psum(psum[p])
         );
      end
   endgenerate

   always_comb begin
      tot = '0;
      for (int p = 0; p < ROOT; p++) tot = tot + TOT_W'(psum[p]);
      y_c = DW'(lms_pkg::clip(64'(tot), DW));
      e_c = DW'(lms_pkg::clip(64'(in_desired) - 64'(y_c), DW));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_y     <= '0;
         out_err   <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_y   <= y_c;
            out_err <= e_c;
         end
      end
   end
endmodule

// File: rtl/lms_part_filter_chk.sv
module lms_part_filter_chk #(
   parameter int DW = 16
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 in_valid,
   input logic signed [DW-1:0] in_desired,
   input logic                 out_valid,
   input logic signed [DW-1:0] out_y,
   input logic signed [DW-1:0] out_err
);
   assert_reset_clear_R1: assert property (@(posedge clk)
      !rst_n |-> (!out_valid && out_y == '0 && out_err == '0));

   assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   assert_valid_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(out_y) && $stable(out_err)));

   assert_err_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_y == $past(in_desired)) |-> out_err == '0);
endmodule

bind lms_part_filter lms_part_filter_chk #(.DW(DW)) chk_i (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_desired(in_desired),
   .out_valid(out_valid), .out_y(out_y), .out_err(out_err)
);

// File: tb/lms_part_filter_tb_top.sv
`timescale 1ns/1ps
module lms_part_filter_tb_top;
   localparam int DW = 16, ROOT = 3, FRAC = 15, MU = 4, TAPS = ROOT * ROOT;

   logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
   logic signed [DW-1:0] in_sample = '0, in_desired = '0;
   logic out_valid;
   logic signed [DW-1:0] out_y, out_err;

   lms_part_filter #(.DW(DW), .ROOT(ROOT), .FRAC(FRAC), .MU_SHIFT(MU)) dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
      .in_desired(in_desired), .out_valid(out_valid), .out_y(out_y), .out_err(out_err));

   always #2 clk = ~clk;

   int n_chk = 0, n_fail = 0, n_sent = 0, n_out = 0;
   longint m_w [TAPS];
   longint m_h [TAPS];
   longint t_h [TAPS];
   longint q_y [$];
   longint q_e [$];
   string  q_tag [$];
   longint last_y = 0, last_e = 0;
   bit     mon_on = 1'b0;
   bit     done = 1'b0;

   function automatic longint sat(input longint v);
      if (v > 32767) return 32767;
      if (v < -32768) return -32768;
      return v;
   endfunction

   function automatic longint rnd(input longint v, input int sh);
      return (v + (longint'(1) <<< (sh - 1))) >>> sh;
   endfunction

   task automatic chk(input string tag, input string what, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic report();
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   endtask

   // driver: model step, push expectation, drive one valid cycle
   task automatic send(input longint x, input longint d, input string tag);
      longint y, e;
      for (int k = TAPS - 1; k > 0; k--) m_h[k] = m_h[k-1];
      m_h[0] = x;
      y = 0;
      for (int k = 0; k < TAPS; k++) y += sat(rnd(m_w[k] * m_h[k], FRAC));
      y = sat(y);
      e = sat(d - y);
      for (int k = 0; k < TAPS; k++) m_w[k] = sat(m_w[k] + sat(rnd(e * m_h[k], FRAC + MU)));
      q_y.push_back(y); q_e.push_back(e); q_tag.push_back(tag);
      n_sent++;
      @(negedge clk);
      in_valid = 1'b1; in_sample = DW'(x); in_desired = DW'(d);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 1'b0;
         in_sample = DW'($urandom); in_desired = DW'($urandom);
      end
   endtask

   // unknown system for training
   function automatic longint plant(input longint x);
      longint g [TAPS] = '{9830, -6554, 3277, 0, 1638, 0, 0, 0, -1000};
      longint s = 0;
      for (int k = TAPS - 1; k > 0; k--) t_h[k] = t_h[k-1];
      t_h[0] = x;
      for (int k = 0; k < TAPS; k++) s += rnd(g[k] * t_h[k], FRAC);
      return sat(s);
   endfunction

   // monitor / scoreboard
   always @(negedge clk) begin
      if (mon_on) begin
         if (out_valid) begin
            n_out++;
            if (q_y.size() == 0) begin
               chk("R2", "unexpected out_valid", 1, 0);
            end else begin
               automatic longint ey = q_y.pop_front();
               automatic longint ee = q_e.pop_front();
               automatic string  tg = q_tag.pop_front();
               chk(tg, "out_y", longint'(out_y), ey);
               chk(tg, "out_err", longint'(out_err), ee);
            end
            last_y = longint'(out_y); last_e = longint'(out_err);
         end else begin
            chk("R3", "idle out_y", longint'(out_y), last_y);
            chk("R3", "idle out_err", longint'(out_err), last_e);
         end
      end
   end

   initial begin
      #(4.0 * 150000);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL R2 watchdog actual=hung expected=finished");
         report();
      end
   end

   initial begin
      for (int k = 0; k < TAPS; k++) begin m_w[k] = 0; m_h[k] = 0; t_h[k] = 0; end
      repeat (3) @(negedge clk);
      chk("R1", "reset out_valid", longint'(out_valid), 0);
      chk("R1", "reset out_y", longint'(out_y), 0);
      chk("R1", "reset out_err", longint'(out_err), 0);
      rst_n = 1'b1;
      mon_on = 1'b1;
      idle(2);

      // R1: zero weights give y=0, err=desired
      send(1000, 5000, "R1");
      idle(3);

      // R4 R5 R6: back-to-back training toward a known system
      for (int i = 0; i < 400; i++) begin
         automatic longint x = longint'($urandom_range(16383)) - 8192;
         send(x, plant(x), "R4 R5 R6");
      end
      idle(2);

      // R3: junk on the inputs while in_valid is low
      for (int i = 0; i < 40; i++) begin
         automatic longint x = longint'($urandom_range(16383)) - 8192;
         send(x, plant(x), "R3");
         idle(1 + (i % 3));
      end

      // R7: full-scale runs drive saturation and rounding edges
      for (int i = 0; i < 30; i++) send(32767, 32767, "R7");
      for (int i = 0; i < 30; i++) send(-32768, 32767, "R7");
      for (int i = 0; i < 20; i++) send(32767, -32768, "R7");
      for (int i = 0; i < 20; i++) send((i % 2) ? 1 : -1, (i % 2) ? -32768 : 32767, "R7");
      idle(4);

      chk("R2", "results pending", longint'(q_y.size()), 0);
      chk("R2", "results vs samples", longint'(n_out), longint'(n_sent));
      done = 1'b1;
      report();
   end
endmodule